// File: doc/BRIEF.md
# Variable-Latency I/O Transfer Controller

This block runs single-word and burst read or write transfers to an asynchronous I/O device whose access time is not fixed. The device paces every data word with a ready line. On the host side the controller takes a request with a direction, a start word address, a beat count, byte enables, write data and two timing fields. The first field is a minimum strobe length and the second is a recovery length between beats. On the device side it drives an active-low chip select, an output-enable strobe for reads, a write-enable strobe for writes, active-low byte selects, a word address and write data. It also samples the ready line and captures read data.

The logic runs on a clock at twice the memory-clock rate. A phase bit marks each fast cycle as the rising-edge slot (phase 0) or the falling-edge slot (phase 1) of the memory clock. Every timing rule can therefore be placed to a half memory cycle. All counts below are in fast cycles, and one memory cycle equals two fast cycles. Chip select falls in a rising-edge slot. The strobe pulses once per beat. A refresh requester can be granted one memory cycle between two beats of a burst, and during that cycle the device bus is idle. A request that arrives while a transfer is running is ignored.

Top module: `varlat_io_ctrl`

## Requirements
- R1: After reset and while idle, chip select, output enable and write enable are high, all byte selects are high, and the refresh grant, read-valid, write-accept and done outputs are low.
- R2: The first strobe of a transfer goes low exactly 4 fast cycles after chip select goes low, and a strobe is never low while chip select is high.
- R3: With ready held high, each strobe stays low for 2*rdf+2 fast cycles. Ready is first sampled 2*(rdf-1) fast cycles after the strobe falls.
- R4: On a read, data from the device bus is captured at the end of the last strobe-low cycle. rd_valid_o is high for exactly that one cycle in which the strobe returns high, and rd_data_o shows the captured word.
- R5: A beat ends only after three consecutive high ready samples taken in a rising, a falling and a rising slot. A low sample restarts the count, and a run of high samples that begins in a falling slot does not count from that slot.
- R6: After the last strobe of a transfer returns high, chip select and the byte selects (driven as the inverse of be_i) stay low for 2 more fast cycles. done_o then pulses for one cycle, in the first cycle that chip select is high.
- R7: Between beats of a burst, the strobe stays high for 2*rdn+2 fast cycles before the next beat's strobe falls.
- R8: The transfer has len_i+1 beats. The word address starts at addr_i and rises by one in the fast cycle after each non-final strobe release. It does not change after the final beat.
- R9: A minimum-strobe field rdf_i of 0 behaves as 1, so the strobe is low for 4 fast cycles with ready high.
- R10: Writes pulse only the write enable and reads pulse only the output enable. Write data is taken from wdata_i at each strobe fall and held on the device bus while that strobe is low. wr_ack_o pulses for one cycle, in the cycle the write strobe returns high.
- R11: A refresh request seen in any cycle of an inter-beat gap, including its last cycle, is granted when the gap ends. ref_gnt_o is high for exactly 2 fast cycles with chip select and both strobes high. Chip select then goes low 4 fast cycles before the next strobe.
- R12: A refresh request outside an inter-beat gap has no effect: no grant is issued and the gap length stays as in R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the memory-clock rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Start a transfer (sampled while idle) |
| wr_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | AW | Start word address |
| len_i | input | LW | Beats in the transfer minus one |
| be_i | input | DW/8 | Byte enables, active high |
| wdata_i | input | DW | Write data for the next beat |
| rdf_i | input | TW | Minimum strobe field in memory cycles |
| rdn_i | input | TW | Recovery field between beats |
| rd_data_o | output | DW | Last captured read word |
| rd_valid_o | output | 1 | One-cycle pulse per read beat |
| wr_ack_o | output | 1 | One-cycle pulse per write beat |
| done_o | output | 1 | One-cycle pulse after chip select release |
| ref_req_i | input | 1 | Refresh slot request |
| ref_gnt_o | output | 1 | Refresh slot granted |
| io_cs_n_o | output | 1 | Device chip select, active low |
| io_oe_n_o | output | 1 | Device output enable, active low |
| io_we_n_o | output | 1 | Device write enable, active low |
| io_be_n_o | output | DW/8 | Device byte selects, active low |
| io_addr_o | output | AW | Device word address |
| io_wdata_o | output | DW | Device write data |
| io_rdata_i | input | DW | Device read data |
| io_rdy_i | input | 1 | Device ready |

## Verification
A refresh request and the end of an inter-beat gap can fall in the same cycle. The grant decision then has to use the request that arrives in that final gap cycle, not only a request already latched. The bench pulses the refresh request for exactly the last gap cycle of a read burst. It checks that the strobe stays high for the full gap, that the grant appears for two cycles with chip select released, and that chip select returns four cycles before the next strobe. In a second run the request is held high in every strobe and idle cycle, but never in a gap. There the bench checks that no grant appears and that the gap keeps its plain length.

// File: rtl/lio_pkg.sv
package lio_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_START,
        S_LEAD,
        S_STRB,
        S_CAPT,
        S_GAP,
        S_REF,
        S_TAIL
    } lio_state_e;

    localparam int LEAD_CYC = 4;
    localparam int REF_CYC  = 2;
    localparam int TAIL_CYC = 2;

endpackage

// File: rtl/lio_phase.sv
module lio_phase (
    input  logic clk,
    input  logic rst_n,
    output logic ph_o
);
    logic ph_d, ph_q;

    always_comb begin
        ph_d = ~ph_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ph_q <= 1'b1;
        else        ph_q <= ph_d;
    end

    assign ph_o = ph_q;
endmodule

// File: rtl/lio_rdy_qual.sv
module lio_rdy_qual #(
    parameter int NEED = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic ph_i,
    input  logic rdy_i,
    output logic hit_o
);
    localparam int CNTW = $clog2(NEED + 1);

    logic [CNTW-1:0] cnt_d, cnt_q;

    assign hit_o = en_i && rdy_i && (cnt_q == CNTW'(NEED - 1));

    always_comb begin
        cnt_d = cnt_q;
        if (!en_i || !rdy_i)               cnt_d = '0;
        else if (cnt_q == '0 && ph_i)      cnt_d = '0;
        else if (hit_o)                    cnt_d = '0;
        else                               cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/varlat_io_ctrl.sv
module varlat_io_ctrl
    import lio_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 32,
    parameter int LW = 4,
    parameter int TW = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_i,
    input  logic            wr_i,
    input  logic [AW-1:0]   addr_i,
    input  logic [LW-1:0]   len_i,
    input  logic [DW/8-1:0] be_i,
    input  logic [DW-1:0]   wdata_i,
    input  logic [TW-1:0]   rdf_i,
    input  logic [TW-1:0]   rdn_i,
    output logic [DW-1:0]   rd_data_o,
    output logic            rd_valid_o,
    output logic            wr_ack_o,
    output logic            done_o,
    input  logic            ref_req_i,
    output logic            ref_gnt_o,
    output logic            io_cs_n_o,
    output logic            io_oe_n_o,
    output logic            io_we_n_o,
    output logic [DW/8-1:0] io_be_n_o,
    output logic [AW-1:0]   io_addr_o,
    output logic [DW-1:0]   io_wdata_o,
    input  logic [DW-1:0]   io_rdata_i,
    input  logic            io_rdy_i
);
    localparam int BW  = DW / 8;
    localparam int CW  = TW + 2;
    localparam logic [CW-1:0] CNT_MAX = '1;

    typedef struct packed {
        lio_state_e    state;
        logic [CW-1:0] cnt;
        logic [AW-1:0] addr;
        logic [LW-1:0] left;
        logic          wr;
        logic [BW-1:0] be;
        logic [TW-1:0] rdf;
        logic [TW-1:0] rdn;
        logic          pend;
        logic [DW-1:0] rdat;
        logic [DW-1:0] wdat;
        logic          dvalid;
        logic          wack;
        logic          done;
    } ctl_t;

    ctl_t r_q, r_d;

    logic          ph;
    logic          samp_en;
    logic          rdy_hit;
    logic [CW-1:0] win_start;
    logic [CW-1:0] gap_end;
    logic [CW-1:0] cnt_inc;
    logic          strobe_on;
    logic          cs_on;

    lio_phase u_phase (
        .clk   (clk),
        .rst_n (rst_n),
        .ph_o  (ph)
    );

    assign win_start = CW'({r_q.rdf - TW'(1), 1'b0});
    assign gap_end   = CW'({r_q.rdn, 1'b1});
    assign samp_en   = (r_q.state == S_STRB) && (r_q.cnt >= win_start);

    lio_rdy_qual #(.NEED(3)) u_rdy (
        .clk   (clk),
        .rst_n (rst_n),
        .en_i  (samp_en),
        .ph_i  (ph),
        .rdy_i (io_rdy_i),
        .hit_o (rdy_hit)
    );

    always_comb begin
        r_d        = r_q;
        r_d.dvalid = 1'b0;
        r_d.wack   = 1'b0;
        r_d.done   = 1'b0;
        cnt_inc    = (r_q.cnt == CNT_MAX) ? r_q.cnt : r_q.cnt + 1'b1;
        r_d.cnt    = cnt_inc;

        unique case (r_q.state)
            S_IDLE: begin
                r_d.cnt = '0;
                if (req_i) begin
                    r_d.state = S_START;
                    r_d.addr  = addr_i;
                    r_d.left  = len_i;
                    r_d.wr    = wr_i;
                    r_d.be    = be_i;
                    r_d.rdf   = (rdf_i == '0) ? TW'(1) : rdf_i;
                    r_d.rdn   = rdn_i;
                    r_d.pend  = 1'b0;
                end
            end
            S_START: begin
                if (ph) begin
                    r_d.state = S_LEAD;
                    r_d.cnt   = '0;
                end
            end
            S_LEAD: begin
                if (r_q.cnt == CW'(LEAD_CYC - 1)) begin
                    r_d.state = S_STRB;
                    r_d.cnt   = '0;
                    r_d.wdat  = wdata_i;
                end
            end
            S_STRB: begin
                if (rdy_hit) begin
                    r_d.state = S_CAPT;
                    r_d.cnt   = '0;
                end
            end
            S_CAPT: begin
                r_d.cnt  = '0;
                r_d.pend = 1'b0;
                if (r_q.wr) begin
                    r_d.wack = 1'b1;
                end else begin
                    r_d.rdat   = io_rdata_i;
                    r_d.dvalid = 1'b1;
                end
                r_d.state = (r_q.left == '0) ? S_TAIL : S_GAP;
            end
            S_GAP: begin
                if (ref_req_i) r_d.pend = 1'b1;
                if (r_q.cnt == '0) begin
                    r_d.addr = r_q.addr + 1'b1;
                    r_d.left = r_q.left - 1'b1;
                end
                if (r_q.cnt == gap_end) begin
                    r_d.cnt = '0;
                    if (r_q.pend || ref_req_i) begin
                        r_d.state = S_REF;
                        r_d.pend  = 1'b0;
                    end else begin
                        r_d.state = S_STRB;
                        r_d.wdat  = wdata_i;
                    end
                end
            end
            S_REF: begin
                if (r_q.cnt == CW'(REF_CYC - 1)) begin
                    r_d.state = S_LEAD;
                    r_d.cnt   = '0;
                end
            end
            S_TAIL: begin
                if (r_q.cnt == CW'(TAIL_CYC - 1)) begin
                    r_d.state = S_IDLE;
                    r_d.cnt   = '0;
                    r_d.done  = 1'b1;
                end
            end
            default: r_d.state = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.state <= S_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign strobe_on = (r_q.state == S_STRB) || (r_q.state == S_CAPT);
    assign cs_on     = (r_q.state == S_LEAD) || strobe_on ||
                       (r_q.state == S_GAP)  || (r_q.state == S_TAIL);

    assign io_cs_n_o  = ~cs_on;
    assign io_oe_n_o  = ~(strobe_on && !r_q.wr);
    assign io_we_n_o  = ~(strobe_on && r_q.wr);
    assign io_be_n_o  = cs_on ? ~r_q.be : '1;
    assign io_addr_o  = r_q.addr;
    assign io_wdata_o = r_q.wdat;
    assign ref_gnt_o  = (r_q.state == S_REF);
    assign rd_data_o  = r_q.rdat;
    assign rd_valid_o = r_q.dvalid;
    assign wr_ack_o   = r_q.wack;
    assign done_o     = r_q.done;
endmodule

// File: rtl/varlat_io_ctrl_chk.sv
module varlat_io_ctrl_chk #(
    parameter int BW = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cs_n,
    input logic          oe_n,
    input logic          we_n,
    input logic [BW-1:0] be_n,
    input logic          gnt,
    input logic          rd_valid,
    input logic          wr_ack,
    input logic          done
);
    // R10
    one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!oe_n && !we_n));

    // R2
    strobe_in_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!oe_n || !we_n) |-> !cs_n);

    // R11
    gnt_bus_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gnt |-> (cs_n && oe_n && we_n));

    // R11
    gnt_min_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gnt) |=> gnt);

    // R11
    gnt_max_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt && $past(gnt)) |=> !gnt);

    // R4
    rd_valid_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> (oe_n && $past(!oe_n)));

    // R10
    wr_ack_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ack |-> (we_n && $past(!we_n)));

    // R6
    done_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (cs_n && $past(!cs_n)));

    // R6
    be_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> (be_n == '1));
endmodule

bind varlat_io_ctrl varlat_io_ctrl_chk #(.BW(DW/8)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_n     (io_cs_n_o),
    .oe_n     (io_oe_n_o),
    .we_n     (io_we_n_o),
    .be_n     (io_be_n_o),
    .gnt      (ref_gnt_o),
    .rd_valid (rd_valid_o),
    .wr_ack   (wr_ack_o),
    .done     (done_o)
);

// File: tb/tb_varlat_io_ctrl.sv
`timescale 1ns/1ps
module tb_varlat_io_ctrl;
    localparam int AW = 16;
    localparam int DW = 32;
    localparam int LW = 4;
    localparam int TW = 4;
    localparam int BW = DW / 8;
    localparam int MAXT = 256;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req = 1'b0;
    logic          wr = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [LW-1:0] len = '0;
    logic [BW-1:0] be = '0;
    logic [DW-1:0] wdata = '0;
    logic [TW-1:0] rdf = '0;
    logic [TW-1:0] rdn = '0;
    logic [DW-1:0] rd_data;
    logic          rd_valid, wr_ack, done;
    logic          ref_req = 1'b0;
    logic          ref_gnt;
    logic          cs_n, oe_n, we_n;
    logic [BW-1:0] be_n;
    logic [AW-1:0] io_addr;
    logic [DW-1:0] io_wdata;
    logic [DW-1:0] io_rdata;
    logic          rdy = 1'b1;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    logic          t_cs [MAXT];
    logic          t_oe [MAXT];
    logic          t_we [MAXT];
    logic          t_gnt[MAXT];
    logic          t_dv [MAXT];
    logic          t_wk [MAXT];
    logic          t_dn [MAXT];
    logic [BW-1:0] t_be [MAXT];
    logic [AW-1:0] t_ad [MAXT];
    logic [DW-1:0] t_rd [MAXT];
    logic [DW-1:0] t_wd [MAXT];
    int            t_len;

    always #2.5 clk = ~clk;

    assign io_rdata = {16'hC0DE, io_addr};

    varlat_io_ctrl #(.AW(AW), .DW(DW), .LW(LW), .TW(TW)) dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_i      (req),
        .wr_i       (wr),
        .addr_i     (addr),
        .len_i      (len),
        .be_i       (be),
        .wdata_i    (wdata),
        .rdf_i      (rdf),
        .rdn_i      (rdn),
        .rd_data_o  (rd_data),
        .rd_valid_o (rd_valid),
        .wr_ack_o   (wr_ack),
        .done_o     (done),
        .ref_req_i  (ref_req),
        .ref_gnt_o  (ref_gnt),
        .io_cs_n_o  (cs_n),
        .io_oe_n_o  (oe_n),
        .io_we_n_o  (we_n),
        .io_be_n_o  (be_n),
        .io_addr_o  (io_addr),
        .io_wdata_o (io_wdata),
        .io_rdata_i (io_rdata),
        .io_rdy_i   (rdy)
    );

    task automatic chk(input bit ok, input string req_tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req_tag, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    endtask

    // kind: 0 cs low, 1 cs high, 2 oe low, 3 oe high, 4 we low, 5 we high, 6 gnt high
    function automatic int find(input int kind, input int from);
        for (int i = from; i < t_len; i++) begin
            case (kind)
                0: if (!t_cs[i]) return i;
                1: if (t_cs[i])  return i;
                2: if (!t_oe[i]) return i;
                3: if (t_oe[i])  return i;
                4: if (!t_we[i]) return i;
                5: if (t_we[i])  return i;
                6: if (t_gnt[i]) return i;
                default: ;
            endcase
        end
        return 0;
    endfunction

    function automatic int count(input int kind);
        int c = 0;
        for (int i = 0; i < t_len; i++) begin
            case (kind)
                0: if (t_dv[i])  c++;
                1: if (t_wk[i])  c++;
                2: if (t_gnt[i]) c++;
                3: if (t_dn[i])  c++;
                4: if (!t_oe[i]) c++;
                default: ;
            endcase
        end
        return c;
    endfunction

    task automatic start(input bit w, input logic [AW-1:0] a, input int beats,
                         input logic [BW-1:0] b, input int f, input int n,
                         input logic [DW-1:0] wd0);
        @(negedge clk);
        wr = w; addr = a; len = LW'(beats - 1); be = b;
        rdf = TW'(f); rdn = TW'(n); wdata = wd0;
        req = 1'b1;
        @(negedge clk);
        req = 1'b0;
    endtask

    // rmode 0: ready always high; 1: high at strobe cycles 2,3 and from 5 on
    // fmode 0: no refresh; 1: one pulse in last cycle of first gap; 2: high outside gaps
    task automatic trace(input int rmode, input int fmode, input int n,
                         input logic [DW-1:0] wd1, input logic [DW-1:0] wd2);
        int  k = 0;
        int  g = -1;
        bit  prev_low = 0;
        bit  gap1_done = 0;
        int  wb = 0;
        bit  seen_done = 0;
        bit  slow;
        t_len = 0;
        for (int t = 0; t < MAXT; t++) begin
            @(negedge clk);
            t_cs[t] = cs_n; t_oe[t] = oe_n; t_we[t] = we_n; t_gnt[t] = ref_gnt;
            t_dv[t] = rd_valid; t_wk[t] = wr_ack; t_dn[t] = done; t_be[t] = be_n;
            t_ad[t] = io_addr; t_rd[t] = rd_data; t_wd[t] = io_wdata;
            t_len = t + 1;
            slow = !oe_n || !we_n;
            k = slow ? (prev_low ? k + 1 : 0) : 0;
            if (!cs_n && !slow && prev_low) g = 0;
            else if (!cs_n && !slow && g >= 0) g++;
            else g = -1;
            prev_low = slow;
            rdy = (rmode == 0) ? 1'b1 : (slow && (k == 2 || k == 3 || k >= 5));
            ref_req = 1'b0;
            if (fmode == 1 && !gap1_done && g == 2 * n + 1) begin
                ref_req = 1'b1;
                gap1_done = 1;
            end
            if (fmode == 2 && (slow || cs_n)) ref_req = 1'b1;
            if (wr_ack) begin
                wb++;
                wdata = (wb == 1) ? wd1 : wd2;
            end
            if (seen_done) break;
            if (done) seen_done = 1;
        end
        ref_req = 1'b0;
        rdy = 1'b1;
        if (!seen_done) chk(0, "watchdog: transfer never finished", t_len, 0);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(cs_n && oe_n && we_n, "R1 strobes idle", {cs_n, oe_n, we_n}, 3'b111);
        chk(be_n == '1, "R1 byte selects idle", be_n, 4'hF);
        chk(!ref_gnt && !rd_valid && !wr_ack && !done, "R1 pulses low",
            {ref_gnt, rd_valid, wr_ack, done}, 0);
    endtask

    task automatic t_single_read();
        int c0, s0, e0, c1;
        start(0, 16'h0100, 1, 4'b0101, 2, 0, '0);
        trace(0, 0, 0, '0, '0);
        c0 = find(0, 0); s0 = find(2, c0); e0 = find(3, s0); c1 = find(1, e0);
        chk(s0 - c0 == 4, "R2 cs to strobe", s0 - c0, 4);
        chk(e0 - s0 == 6, "R3 strobe width rdf=2", e0 - s0, 6);
        chk(t_dv[e0] && t_rd[e0] == 32'hC0DE0100, "R4 read capture", t_rd[e0], 32'hC0DE0100);
        chk(count(0) == 1, "R4 one valid pulse", count(0), 1);
        chk(c1 - e0 == 2, "R6 cs hold after strobe", c1 - e0, 2);
        chk(t_dn[c1] && count(3) == 1, "R6 done pulse", count(3), 1);
        chk(t_be[c0] == 4'b1010 && t_be[c1 - 1] == 4'b1010, "R6 byte selects held",
            t_be[c1 - 1], 4'b1010);
        chk(t_be[c1] == 4'hF, "R6 byte selects released", t_be[c1], 4'hF);
    endtask

    task automatic t_clamp();
        int s0, e0;
        start(0, 16'h0200, 1, 4'hF, 0, 0, '0);
        trace(0, 0, 0, '0, '0);
        s0 = find(2, 0); e0 = find(3, s0);
        chk(e0 - s0 == 4, "R9 rdf zero clamps to one", e0 - s0, 4);
    endtask

    task automatic t_wide();
        int s0, e0;
        start(0, 16'h0280, 1, 4'hF, 5, 0, '0);
        trace(0, 0, 0, '0, '0);
        s0 = find(2, 0); e0 = find(3, s0);
        chk(e0 - s0 == 12, "R3 strobe width rdf=5", e0 - s0, 12);
    endtask

    task automatic t_ready_wait();
        int s0, e0;
        start(0, 16'h0300, 1, 4'hF, 2, 0, '0);
        trace(1, 0, 0, '0, '0);
        s0 = find(2, 0); e0 = find(3, s0);
        chk(e0 - s0 == 10, "R5 restart after low sample", e0 - s0, 10);
        chk(t_rd[e0] == 32'hC0DE0300, "R5 data after wait", t_rd[e0], 32'hC0DE0300);
    endtask

    task automatic t_burst_read();
        int s, e, c1, nv;
        start(0, 16'h0400, 3, 4'hF, 1, 1, '0);
        trace(0, 0, 1, '0, '0);
        s = find(2, 0);
        nv = 0;
        for (int b = 0; b < 3; b++) begin
            e = find(3, s);
            chk(t_ad[s] == AW'(16'h0400 + b), "R8 address per beat", t_ad[s], 16'h0400 + b);
            chk(e - s == 4, "R3 burst strobe width", e - s, 4);
            chk(t_dv[e] && t_rd[e] == {16'hC0DE, AW'(16'h0400 + b)}, "R4 burst data",
                t_rd[e], {16'hC0DE, AW'(16'h0400 + b)});
            if (b < 2) begin
                chk(t_ad[e] == AW'(16'h0400 + b) && t_ad[e + 1] == AW'(16'h0401 + b),
                    "R8 address advance point", t_ad[e + 1], 16'h0401 + b);
                s = find(2, e);
                chk(s - e == 4, "R7 gap rdn=1", s - e, 4);
            end else begin
                c1 = find(1, e);
                chk(t_ad[c1] == 16'h0402, "R8 no advance after last", t_ad[c1], 16'h0402);
            end
        end
        chk(count(0) == 3, "R8 beat count", count(0), 3);
    endtask

    task automatic t_burst_write();
        int s, e;
        start(1, 16'h0500, 2, 4'b0011, 1, 0, 32'h1111_AAAA);
        trace(0, 0, 0, 32'h2222_BBBB, 32'h3333_CCCC);
        chk(count(4) == 0, "R10 oe idle on write", count(4), 0);
        chk(count(0) == 0 && count(1) == 2, "R10 accept pulses", count(1), 2);
        s = find(4, 0);
        for (int b = 0; b < 2; b++) begin
            e = find(5, s);
            chk(t_wd[s] == (b == 0 ? 32'h1111_AAAA : 32'h2222_BBBB) && t_wd[e - 1] == t_wd[s],
                "R10 write data per beat", t_wd[s], (b == 0 ? 32'h1111_AAAA : 32'h2222_BBBB));
            chk(t_wk[e] && e - s == 4, "R10 accept at release", e - s, 4);
            chk(t_be[s] == 4'b1100, "R10 byte selects on write", t_be[s], 4'b1100);
            if (b == 0) begin
                s = find(4, e);
                chk(s - e == 2, "R7 gap rdn=0", s - e, 2);
            end
        end
    endtask

    task automatic t_refresh();
        int s0, e0, gi, s1;
        start(0, 16'h0600, 2, 4'hF, 1, 2, '0);
        trace(0, 1, 2, '0, '0);
        s0 = find(2, 0); e0 = find(3, s0);
        gi = find(6, e0); s1 = find(2, e0);
        chk(gi - e0 == 6, "R11 grant after full gap", gi - e0, 6);
        chk(count(2) == 2, "R11 grant length", count(2), 2);
        chk(t_cs[gi] && t_cs[gi + 1] && t_oe[gi], "R11 bus idle in grant", t_cs[gi], 1);
        chk(!t_cs[gi + 2] && s1 - (gi + 2) == 4, "R11 cs lead before strobe", s1 - (gi + 2), 4);
        chk(t_rd[find(3, s1)] == 32'hC0DE0601, "R11 beat after refresh",
            t_rd[find(3, s1)], 32'hC0DE0601);
    endtask

    task automatic t_refresh_ignored();
        int s0, e0, s1;
        start(0, 16'h0700, 2, 4'hF, 1, 0, '0);
        trace(0, 2, 0, '0, '0);
        s0 = find(2, 0); e0 = find(3, s0); s1 = find(2, e0);
        chk(count(2) == 0, "R12 no grant outside gap", count(2), 0);
        chk(s1 - e0 == 2, "R12 gap unchanged", s1 - e0, 2);
    endtask

    initial begin
        #(5ns * 20000);
        chk(0, "watchdog expired", 0, 1);
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_single_read();
        t_clamp();
        t_wide();
        t_ready_wait();
        t_burst_read();
        t_burst_write();
        t_refresh();
        t_refresh_ignored();
        repeat (3) @(negedge clk);
        summary();
    end
endmodule